// File: doc/BRIEF.md
# Store-Conditional Reservation Monitor

This block sits next to a core's data cache and decides whether each store-conditional may go ahead. A load-linked request stores the cache line of its address in a single reservation slot and marks it live. The reservation is cancelled by any of these events:

- a newer load-linked, which replaces it;
- a snooped invalidation or ownership request from another core that hits the reserved line;
- any other memory access made by the local core;
- a synchronous clear issued for a context switch or exception;
- any store-conditional, whether it passes or fails.

Each store-conditional is answered one cycle after the request, with a response strobe and a pass bit. The store may be performed only when the pass bit is set.

Addresses are compared at cache-line granularity. The low `log2(LINE_BYTES)` address bits are ignored, so with the default 64-byte line, bits 5..0 take no part in any comparison. Several events may arrive in the same cycle, and fixed rules decide the outcome. Only one reservation exists, so reservation pairs cannot be nested or interleaved.

Top module: `resv_monitor`

## Requirements
- R1: After reset no reservation is live, `sc_rsp_valid` is 0, and a store-conditional issued before any load-linked fails.
- R2: `sc_rsp_valid` is 1 in the cycle after a cycle with `sc_req` high, and 0 after a cycle without it. `sc_pass` is meaningful only when `sc_rsp_valid` is 1.
- R3: A store-conditional passes only when a reservation is live and its address falls in the reserved line. Two addresses fall in the same line when bits ADDR_W-1..6 are equal (64-byte line). Otherwise it fails.
- R4: A load-linked replaces any earlier reservation. A later store-conditional to the earlier line fails, and one to the new line passes.
- R5: A snoop (`snp_req`) whose address falls in the reserved line cancels the reservation. A snoop to a different line leaves the reservation intact.
- R6: A local access (`loc_acc`) cancels the reservation. A store-conditional in the same cycle as a local access fails.
- R7: Every store-conditional cancels the reservation, whether it passes or fails.
- R8: A snoop hitting the reserved line in the same cycle as a store-conditional to that line makes the store-conditional fail.
- R9: `ctx_clr` cancels the reservation. It makes a same-cycle store-conditional fail, and it overrides a same-cycle load-linked.
- R10: A load-linked and a store-conditional in the same cycle: the store-conditional is judged against the reservation that existed before that cycle, and the load-linked's reservation remains live afterwards.
- R11: A load-linked whose line is hit by a snoop in the same cycle leaves no live reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_req | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked byte address |
| sc_req | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| snp_req | input | 1 | Remote invalidation or ownership request |
| snp_addr | input | ADDR_W | Snooped byte address |
| loc_acc | input | 1 | Any other local memory access |
| ctx_clr | input | 1 | Synchronous reservation clear |
| sc_rsp_valid | output | 1 | Store-conditional result strobe |
| sc_pass | output | 1 | Store-conditional may write (1) or fails (0) |

## Verification
A store-conditional can share its cycle with a snoop, a local access, a clear or a new load-linked. The harder pairing is a store-conditional and a snoop to the same line, because the monitor must veto a store that would otherwise pass. The bench provokes each pairing directly after establishing a matching reservation, and checks the pass bit one cycle later against a literal expectation. A randomized phase then drives all ports at once over a few cache lines. A behavioural model in the bench judges every cycle's strobe and pass bit.

// File: rtl/resv_pkg.sv
package resv_pkg;

    // Next-cycle fate of the reservation slot.
    typedef enum logic [1:0] {
        RV_KEEP = 2'd0,
        RV_LOAD = 2'd1,
        RV_DROP = 2'd2
    } resv_act_e;

endpackage

// File: rtl/resv_line_cmp.sv
module resv_line_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 6
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);
    // Offset bits inside a line never take part in the comparison.
    always_comb begin
        same_line = (addr_a[ADDR_W-1:OFS_W] == addr_b[ADDR_W-1:OFS_W]);
    end
endmodule

// File: rtl/resv_arb.sv
module resv_arb
    import resv_pkg::*;
(
    input  logic      ll_req,
    input  logic      sc_req,
    input  logic      loc_acc,
    input  logic      ctx_clr,
    input  logic      hit_resv,
    input  logic      hit_new,
    output resv_act_e act,
    output logic      sc_veto
);
    // Same-cycle events that forbid a store-conditional from passing.
    always_comb begin
        sc_veto = hit_resv | loc_acc | ctx_clr;
    end

    // Priority: clear, then load-linked (killed by a snoop on its own line),
    // then any cancelling event.
    always_comb begin
        if (ctx_clr) begin
            act = RV_DROP;
        end else if (ll_req) begin
            act = hit_new ? RV_DROP : RV_LOAD;
        end else if (sc_req | loc_acc | hit_resv) begin
            act = RV_DROP;
        end else begin
            act = RV_KEEP;
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_req,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snp_req,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              loc_acc,
    input  logic              ctx_clr,
    output logic              sc_rsp_valid,
    output logic              sc_pass
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic              live;
        logic [LINE_W-1:0] line;
        logic              rsp_v;
        logic              pass;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [ADDR_W-1:0] resv_addr;
    logic              sc_eq_resv;
    logic              snp_eq_resv;
    logic              snp_eq_ll;
    logic              hit_resv;
    logic              hit_new;
    logic              sc_veto;
    resv_act_e         act;

    always_comb begin
        resv_addr = {st_q.line, {OFS_W{1'b0}}};
    end

    resv_line_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_cmp_sc (
        .addr_a(sc_addr), .addr_b(resv_addr), .same_line(sc_eq_resv)
    );
    resv_line_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_cmp_snp (
        .addr_a(snp_addr), .addr_b(resv_addr), .same_line(snp_eq_resv)
    );
    resv_line_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_cmp_new (
        .addr_a(snp_addr), .addr_b(ll_addr), .same_line(snp_eq_ll)
    );

    always_comb begin
        hit_resv = snp_req & st_q.live & snp_eq_resv;
        hit_new  = snp_req & snp_eq_ll;
    end

    resv_arb i_arb (
        .ll_req  (ll_req),
        .sc_req  (sc_req),
        .loc_acc (loc_acc),
        .ctx_clr (ctx_clr),
        .hit_resv(hit_resv),
        .hit_new (hit_new),
        .act     (act),
        .sc_veto (sc_veto)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = sc_req;
        st_d.pass  = sc_req & st_q.live & sc_eq_resv & ~sc_veto;
        case (act)
            RV_LOAD: begin
                st_d.live = 1'b1;
                st_d.line = ll_addr[ADDR_W-1:OFS_W];
            end
            RV_DROP: st_d.live = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sc_rsp_valid = st_q.rsp_v;
        sc_pass      = st_q.pass;
    end

    a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> sc_rsp_valid);
    a_r2_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> !sc_rsp_valid);
    a_r2_pass_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_rsp_valid);
    a_r8_snoop_vetoes_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && snp_req && (snp_addr[ADDR_W-1:OFS_W] == sc_addr[ADDR_W-1:OFS_W]))
        |=> !sc_pass);
    a_r6_local_vetoes_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && loc_acc) |=> !sc_pass);
    a_r9_clear_vetoes_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && ctx_clr) |=> !sc_pass);
    a_r7_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !ll_req) ##1 sc_req |=> !sc_pass);
    a_r1_live_state_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(st_q.live));
endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
    localparam int PERIOD = 10;
    localparam int AW     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_req = 0, sc_req = 0, snp_req = 0, loc_acc = 0, ctx_clr = 0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snp_addr = '0;
    logic          sc_rsp_valid, sc_pass;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // behavioural reference
    bit        m_live = 0;
    bit [25:0] m_line = 0;
    bit        e_v = 0, e_pass = 0;

    always #(PERIOD/2) clk = ~clk;

    resv_monitor #(.ADDR_W(AW), .LINE_BYTES(64)) i_resv_monitor (
        .clk(clk), .rst_n(rst_n),
        .ll_req(ll_req), .ll_addr(ll_addr),
        .sc_req(sc_req), .sc_addr(sc_addr),
        .snp_req(snp_req), .snp_addr(snp_addr),
        .loc_acc(loc_acc), .ctx_clr(ctx_clr),
        .sc_rsp_valid(sc_rsp_valid), .sc_pass(sc_pass)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_live = 0; e_v = 0; e_pass = 0;
        end else begin
            bit hit;
            hit    = snp_req && m_live && (snp_addr / 64 == m_line);
            e_v    = sc_req;
            e_pass = sc_req && m_live && (sc_addr / 64 == m_line)
                     && !hit && !loc_acc && !ctx_clr;
            if (ctx_clr) m_live = 0;
            else if (ll_req) begin
                m_live = !(snp_req && (snp_addr / 64 == ll_addr / 64));
                m_line = 26'(ll_addr / 64);
            end else if (sc_req || loc_acc || hit) m_live = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (sc_rsp_valid !== e_v || (e_v && sc_pass !== e_pass)) begin
                errors++;
                $display("FAIL %s model: valid=%0b pass=%0b expected valid=%0b pass=%0b",
                         tag, sc_rsp_valid, sc_pass, e_v, e_pass);
            end
        end
    end

    task automatic step(input bit ll, input logic [AW-1:0] la,
                        input bit sc, input logic [AW-1:0] sa,
                        input bit sn, input logic [AW-1:0] na,
                        input bit lo, input bit cl);
        ll_req = ll; ll_addr = la; sc_req = sc; sc_addr = sa;
        snp_req = sn; snp_addr = na; loc_acc = lo; ctx_clr = cl;
        @(posedge clk); #1;
        ll_req = 0; sc_req = 0; snp_req = 0; loc_acc = 0; ctx_clr = 0;
    endtask

    task automatic expect_sc(input bit exp, input string req);
        checks++;
        if (sc_rsp_valid !== 1'b1 || sc_pass !== exp) begin
            errors++;
            $display("FAIL %s: valid=%0b pass=%0b expected valid=1 pass=%0b",
                     req, sc_rsp_valid, sc_pass, exp);
        end
    endtask

    task automatic ll_only(input logic [AW-1:0] a);
        step(1, a, 0, '0, 0, '0, 0, 0);
    endtask

    task automatic sc_only(input logic [AW-1:0] a);
        step(0, '0, 1, a, 0, '0, 0, 0);
    endtask

    localparam logic [AW-1:0] A = 32'h0000_1000;
    localparam logic [AW-1:0] B = 32'h0000_2040;

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 3 + 2);
        checks++;                                   // R1 reset state
        if (sc_rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%0b expected 0", sc_rsp_valid);
        end
        rst_n = 1;
        @(posedge clk); #1;
        tag = "R1"; sc_only(A); expect_sc(0, "R1");
        tag = "R2";
        step(0, '0, 0, '0, 0, '0, 0, 0);
        checks++;
        if (sc_rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: valid=%0b expected 0", sc_rsp_valid);
        end
        tag = "R3"; ll_only(A); sc_only(A + 8);  expect_sc(1, "R3");
        tag = "R7"; sc_only(A);                  expect_sc(0, "R7");
        tag = "R3"; ll_only(A); sc_only(A + 64); expect_sc(0, "R3");
        tag = "R7"; sc_only(A);                  expect_sc(0, "R7");
        tag = "R4"; ll_only(A); ll_only(B); sc_only(A); expect_sc(0, "R4");
        ll_only(A); ll_only(B); sc_only(B + 63);        expect_sc(1, "R4");
        tag = "R5"; ll_only(A); step(0, '0, 0, '0, 1, B, 0, 0); sc_only(A);
        expect_sc(1, "R5");
        ll_only(A); step(0, '0, 0, '0, 1, A + 5, 0, 0); sc_only(A);
        expect_sc(0, "R5");
        tag = "R6"; ll_only(A); step(0, '0, 0, '0, 0, '0, 1, 0); sc_only(A);
        expect_sc(0, "R6");
        ll_only(A); step(0, '0, 1, A, 0, '0, 1, 0); expect_sc(0, "R6");
        tag = "R8"; ll_only(A); step(0, '0, 1, A, 1, A + 9, 0, 0);
        expect_sc(0, "R8");
        tag = "R9"; ll_only(A); step(0, '0, 0, '0, 0, '0, 0, 1); sc_only(A);
        expect_sc(0, "R9");
        ll_only(A); step(0, '0, 1, A, 0, '0, 0, 1); expect_sc(0, "R9");
        step(1, A, 0, '0, 0, '0, 0, 1); sc_only(A);  expect_sc(0, "R9");
        tag = "R10"; ll_only(A); step(1, B, 1, A, 0, '0, 0, 0);
        expect_sc(1, "R10");
        sc_only(B); expect_sc(1, "R10");
        tag = "R11"; step(1, A, 0, '0, 1, A + 1, 0, 0); sc_only(A);
        expect_sc(0, "R11");

        tag = "R3 random";
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) == 0, 32'($urandom_range(0, 3) * 64 + $urandom_range(0, 63)),
                 $urandom_range(0, 2) == 0, 32'($urandom_range(0, 3) * 64 + $urandom_range(0, 63)),
                 $urandom_range(0, 5) == 0, 32'($urandom_range(0, 3) * 64 + $urandom_range(0, 63)),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0);
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule